// File: doc/BRIEF.md
# SPI Byte Controller with Bus-Contention Detection

This block is a byte-wide serial peripheral that can work as the clock-driving side or the clock-following side of an SPI link. Software selects the role through a control register. A status bit reports a finished byte, and an interrupt line can follow it. When the block drives the clock, it divides the system clock by a fixed amount and exchanges one byte each time the data register is written. When it follows, it samples an external clock through synchronisers and shifts whenever its select input is low.

The select input also decides who owns the bus. If the select line is set up as an input while the block is driving the clock, a low level on that line means another device has taken the bus. The block then drops back to follower at once, stops the byte in progress, releases its clock and data outputs, and raises the completion flag. It stays a follower until software sets the role bit again. As a follower, a rising select discards any partial byte and puts the bit counter back to zero, so that each byte starts on a clean boundary.

Top module: `spi_mf_ctrl`

## Requirements
- R1: After reset the control register (address 0) and the status register (address 1) read zero, and sck_oe, mosi_oe, miso_oe, ssel_oe and irq are low. Control bits: 0 irq enable, 1 block enable, 2 role (1 = clock driver), 3 select direction (1 = output), 4 follower MISO drive, 5 select output level. Status bit 7 is the completion flag. Address 2 is the data register.
- R2: miso_oe is high only when the block is enabled, the role bit is 0, the synchronised select is low and control bit 4 is set. As a follower, sck_oe and mosi_oe are low.
- R3: While select is high, a follower ignores SCK edges: no flag is set and the received data does not change.
- R4: When select rises in follower role, the partial byte is dropped, no flag is set, and the next byte after select falls again is received whole.
- R5: In the driver role, a write to address 2 exchanges one byte MSB first in mode 0. SCK idles low, each half period lasts HALF_DIV clocks, MISO is sampled on the rising edge, and the received byte can be read at address 2.
- R6: In follower role, a full byte clocked in mode 0 returns the byte last written to address 2 on MISO, MSB first. It sets the flag and makes the MOSI byte readable at address 2.
- R7: In the driver role with control bit 3 clear, a synchronised low select clears control bit 2 and sets the flag. It also forces sck_o low, lowers sck_oe and mosi_oe, and aborts the byte in progress without updating the received data.
- R8: irq equals the flag ANDed with control bit 0 and with the glb_irq_en input.
- R9: After a mode fault, writes to address 2 start no clock activity until software sets control bit 2 again.
- R10: In the driver role with control bit 3 set, ssel_oe is high, ssel_o follows control bit 5, and a low select input causes no fault.
- R11: The flag clears only when a status read that sees it set is followed by an access to address 2. A data access without that status read leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used for flag clearing) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| glb_irq_en | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock pin input |
| sck_o | output | 1 | Serial clock pin output |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | MOSI pin input |
| mosi_o | output | 1 | MOSI pin output |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO pin input |
| miso_o | output | 1 | MISO pin output |
| miso_oe | output | 1 | MISO output enable |
| ssel_i | input | 1 | Select pin input |
| ssel_o | output | 1 | Select pin output level |
| ssel_oe | output | 1 | Select pin output enable |

## Verification
If the bit counter goes out of step, the completion flag comes early or late. The byte read back then looks shifted, as soon as the next byte ends. That is why a partial follower byte is followed by a full byte and a check of the exact value. If the role bit is wrong, it shows within a few clocks after the select falls, on sck_oe, mosi_oe and the control readback. A clock generator that keeps running after an abort shows as SCK toggling while the role bit reads zero. A sequencer for flag clearing that is wrong shows on the next status read.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;
   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_STAT = 2'd1,
      REG_DATA = 2'd2
   } reg_sel_e;

   localparam int CTL_W    = 6;
   localparam int CTL_IRQ  = 0;
   localparam int CTL_ENA  = 1;
   localparam int CTL_MST  = 2;
   localparam int CTL_SDIR = 3;
   localparam int CTL_MDRV = 4;
   localparam int CTL_SLVL = 5;
endpackage

// File: rtl/spi_mf_sync.sv
module spi_mf_sync #(
   parameter int          WIDTH  = 1,
   parameter int          STAGES = 2,
   parameter logic [WIDTH-1:0] INIT = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_mf_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stg_q [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= INIT;
            else if (s == 0) stg_q[s] <= d;
            else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spi_mf_clkgen.sv
module spi_mf_clkgen #(
   parameter int HALF_DIV = 4,
   parameter int BITS     = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic abort,
   output logic sck,
   output logic rise,
   output logic fall,
   output logic busy
);
   localparam int HALVES = 2 * BITS;
   localparam int HW     = $clog2(HALVES + 1);
   localparam int DW     = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("spi_mf_clkgen: HALF_DIV must be at least 1");
      end
   endgenerate

   logic          run_q, sck_q;
   logic [DW-1:0] div_q;
   logic [HW-1:0] half_q;
   logic          tick;

   assign tick = run_q && (div_q == DW'(HALF_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         sck_q  <= 1'b0;
         div_q  <= '0;
         half_q <= '0;
      end else if (abort) begin
         run_q  <= 1'b0;
         sck_q  <= 1'b0;
         div_q  <= '0;
         half_q <= '0;
      end else if (!run_q) begin
         if (start) begin
            run_q  <= 1'b1;
            div_q  <= '0;
            half_q <= '0;
         end
      end else if (tick) begin
         div_q  <= '0;
         sck_q  <= ~sck_q;
         half_q <= half_q + 1'b1;
         if (half_q == HW'(HALVES - 1)) run_q <= 1'b0;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

   assign sck  = sck_q;
   assign rise = tick && !sck_q && !abort;
   assign fall = tick && sck_q && !abort;
   assign busy = run_q;

   AST_SCK_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      sck_q |-> run_q); // R5
   AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!run_q && !sck_q)); // R7
endmodule

// File: rtl/spi_mf_shifter.sv
module spi_mf_shifter #(
   parameter int BITS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [BITS-1:0] load_val,
   input  logic            clr,
   input  logic            rise,
   input  logic            fall,
   input  logic            din,
   output logic            dout,
   output logic            done,
   output logic [BITS-1:0] rx
);
   localparam int CW = (BITS > 1) ? $clog2(BITS) : 1;

   generate
      if (BITS < 2) begin : g_bad_bits
         $error("spi_mf_shifter: BITS must be at least 2");
      end
   endgenerate

   logic [BITS-1:0] sh_q, rx_q;
   logic [CW-1:0]   cnt_q;
   logic            samp_q, done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         rx_q   <= '0;
         cnt_q  <= '0;
         samp_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (load) begin
            sh_q   <= load_val;
            cnt_q  <= '0;
            samp_q <= 1'b0;
         end else if (clr) begin
            cnt_q  <= '0;
            samp_q <= 1'b0;
         end else if (rise) begin
            samp_q <= din;
            if (cnt_q == CW'(BITS - 1)) begin
               cnt_q  <= '0;
               done_q <= 1'b1;
               rx_q   <= {sh_q[BITS-2:0], din};
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else if (fall) begin
            sh_q <= {sh_q[BITS-2:0], samp_q};
         end
      end
   end

   assign dout = sh_q[BITS-1];
   assign done = done_q;
   assign rx   = rx_q;

   AST_CLEAR_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0 && !done_q)); // R4
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R6
endmodule

// File: rtl/spi_mf_ctrl.sv
module spi_mf_ctrl
   import spi_mf_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int HALF_DIV    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              glb_irq_en,
   output logic              irq,
   input  logic              sck_i,
   output logic              sck_o,
   output logic              sck_oe,
   input  logic              mosi_i,
   output logic              mosi_o,
   output logic              mosi_oe,
   input  logic              miso_i,
   output logic              miso_o,
   output logic              miso_oe,
   input  logic              ssel_i,
   output logic              ssel_o,
   output logic              ssel_oe
);
   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("spi_mf_ctrl: DATA_W must be at least 8");
      end
   endgenerate

   logic [CTL_W-1:0]  ctrl_q;
   logic              flag_q, armed_q;
   logic [2:0]        pins_s;
   logic              ssel_s, sck_s, mosi_s, sck_d;
   logic              master, fault, slave_on, s_rise, s_fall;
   logic              m_sck, m_rise, m_fall, m_busy;
   logic              wr_ctl, wr_dat, rd_sta, acc_dat;
   logic              sh_load, sh_clr, sh_rise, sh_fall, sh_din, sh_dout, sh_done;
   logic [DATA_W-1:0] sh_rx;

   spi_mf_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .INIT(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({ssel_i, sck_i, mosi_i}), .q(pins_s));
   assign {ssel_s, sck_s, mosi_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else sck_d <= sck_s;
   end

   assign master   = ctrl_q[CTL_ENA] && ctrl_q[CTL_MST];
   assign fault    = master && !ctrl_q[CTL_SDIR] && !ssel_s;
   assign slave_on = ctrl_q[CTL_ENA] && !ctrl_q[CTL_MST] && !ssel_s;
   assign s_rise   = slave_on && sck_s && !sck_d;
   assign s_fall   = slave_on && !sck_s && sck_d;

   assign wr_ctl  = reg_wr && (reg_addr == REG_CTRL);
   assign wr_dat  = reg_wr && (reg_addr == REG_DATA);
   assign rd_sta  = reg_rd && (reg_addr == REG_STAT);
   assign acc_dat = (reg_wr || reg_rd) && (reg_addr == REG_DATA);

   spi_mf_clkgen #(.HALF_DIV(HALF_DIV), .BITS(DATA_W)) u_clkgen (
      .clk(clk), .rst_n(rst_n),
      .start(wr_dat && master && !fault),
      .abort(fault),
      .sck(m_sck), .rise(m_rise), .fall(m_fall), .busy(m_busy));

   assign sh_load = wr_dat && !m_busy && !slave_on && !fault;
   assign sh_clr  = fault || !(master || slave_on);
   assign sh_rise = master ? m_rise : s_rise;
   assign sh_fall = master ? m_fall : s_fall;
   assign sh_din  = master ? miso_i : mosi_s;

   spi_mf_shifter #(.BITS(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .load(sh_load), .load_val(reg_wdata), .clr(sh_clr),
      .rise(sh_rise), .fall(sh_fall), .din(sh_din),
      .dout(sh_dout), .done(sh_done), .rx(sh_rx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         flag_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         if (wr_ctl) ctrl_q <= reg_wdata[CTL_W-1:0];
         if (fault)  ctrl_q[CTL_MST] <= 1'b0;

         if (sh_done || fault)        flag_q <= 1'b1;
         else if (armed_q && acc_dat) flag_q <= 1'b0;

         if (rd_sta && flag_q) armed_q <= 1'b1;
         else if (acc_dat)     armed_q <= 1'b0;
      end
   end

   always_comb begin
      case (reg_addr)
         REG_CTRL: reg_rdata = {{(DATA_W-CTL_W){1'b0}}, ctrl_q};
         REG_STAT: reg_rdata = {flag_q, {(DATA_W-1){1'b0}}};
         REG_DATA: reg_rdata = sh_rx;
         default:  reg_rdata = '0;
      endcase
   end

   assign irq     = flag_q && ctrl_q[CTL_IRQ] && glb_irq_en;
   assign sck_o   = m_sck;
   assign sck_oe  = master;
   assign mosi_o  = sh_dout;
   assign mosi_oe = master;
   assign miso_o  = sh_dout;
   assign miso_oe = slave_on && ctrl_q[CTL_MDRV];
   assign ssel_o  = ctrl_q[CTL_SLVL];
   assign ssel_oe = master && ctrl_q[CTL_SDIR];

   AST_FAULT_DEMOTES: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> (!ctrl_q[CTL_MST] && flag_q)); // R7
   AST_FAULT_RELEASES_SCK: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> (!sck_o && !sck_oe && !mosi_oe)); // R7
   AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
      sck_oe |-> !miso_oe); // R2
   AST_FAULT_KEEPS_RX: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> $stable(sh_rx)); // R7
endmodule

// File: tb/test_spi_mf_ctrl.sv
module test_spi_mf_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       glb_irq_en = 1'b0, irq;
   logic       sck_i = 1'b0, sck_o, sck_oe;
   logic       mosi_i = 1'b0, mosi_o, mosi_oe;
   logic       miso_i = 1'b0, miso_o, miso_oe;
   logic       ssel_i = 1'b1, ssel_o, ssel_oe;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   spi_mf_ctrl i_spi_mf_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .glb_irq_en(glb_irq_en), .irq(irq),
      .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_i(mosi_i), .mosi_o(mosi_o),
      .mosi_oe(mosi_oe), .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
      .ssel_i(ssel_i), .ssel_o(ssel_o), .ssel_oe(ssel_oe));

   localparam logic [15:0] VEC [0:3] = '{16'hA53C, 16'h0FF0, 16'h8001, 16'h6E97};

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic clear_flag();
      logic [7:0] t;
      rd(2'd1, t);
      rd(2'd2, t);
   endtask

   task automatic m_xfer(input logic [7:0] tx, input logic [7:0] sv, output logic [7:0] cap);
      miso_i = sv[7];
      wr(2'd2, tx);
      for (int i = 7; i >= 0; i--) begin
         @(posedge sck_o);
         cap[i] = mosi_o;
         @(negedge sck_o);
         if (i > 0) miso_i = sv[i-1];
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic s_xfer(input logic [7:0] mo, input int nbits, output logic [7:0] got);
      got = 8'h00;
      for (int i = 0; i < nbits; i++) begin
         mosi_i = mo[7-i];
         repeat (6) @(negedge clk);
         sck_i = 1'b1;
         got[7-i] = miso_o;
         repeat (6) @(negedge clk);
         sck_i = 1'b0;
      end
      repeat (6) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] v, cap, got;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      rd(2'd0, v); check(v == 8'h00, "R1 ctrl", v, 0);
      rd(2'd1, v); check(v == 8'h00, "R1 status", v, 0);
      check({sck_oe, mosi_oe, miso_oe, ssel_oe, irq} == 5'b0, "R1 enables",
            {sck_oe, mosi_oe, miso_oe, ssel_oe, irq}, 0);

      // R5 driver exchanges from the vector table
      wr(2'd0, 8'h0E);
      for (int k = 0; k < 4; k++) begin
         m_xfer(VEC[k][15:8], VEC[k][7:0], cap);
         rd(2'd1, v); check(v[7], "R5 flag", v, 8'h80);
         rd(2'd2, v); check(v == VEC[k][7:0], "R5 rx", v, VEC[k][7:0]);
         check(cap == VEC[k][15:8], "R5 mosi", cap, VEC[k][15:8]);
         check(sck_o == 1'b0, "R5 sck idle", sck_o, 0);
         rd(2'd1, v); check(v == 8'h00, "R11 cleared", v, 0);
      end

      // R10 select as output: level, enable, low input ignored
      wr(2'd0, 8'h2E);
      ssel_i = 1'b0;
      repeat (5) @(negedge clk);
      check(ssel_oe && ssel_o, "R10 ssel drive", {ssel_oe, ssel_o}, 3);
      m_xfer(8'h5A, 8'hC3, cap);
      rd(2'd0, v); check(v[2], "R10 role kept", v, 8'h2E);
      rd(2'd1, v);
      rd(2'd2, v); check(v == 8'hC3, "R10 rx", v, 8'hC3);
      ssel_i = 1'b1;

      // R7 mode fault mid-byte, R8 irq gating
      wr(2'd0, 8'h07);
      glb_irq_en = 1'b1;
      repeat (4) @(negedge clk);
      wr(2'd2, 8'hFF);
      repeat (3) @(posedge sck_o);
      ssel_i = 1'b0;
      repeat (5) @(negedge clk);
      rd(2'd0, v); check(v == 8'h03, "R7 role cleared", v, 3);
      check(!sck_oe && !mosi_oe && !sck_o, "R7 pins released", {sck_oe, mosi_oe, sck_o}, 0);
      check(irq == 1'b1, "R8 irq on", irq, 1);
      glb_irq_en = 1'b0;
      #1 check(irq == 1'b0, "R8 global gate", irq, 0);
      ssel_i = 1'b1;
      repeat (5) @(negedge clk);
      rd(2'd1, v); check(v[7], "R7 flag", v, 8'h80);
      rd(2'd2, v); check(v == 8'hC3, "R7 rx kept", v, 8'hC3);
      rd(2'd1, v); check(v == 8'h00, "R11 cleared after fault", v, 0);

      // R9 stays follower until rewritten
      wr(2'd2, 8'h11);
      repeat (40) @(negedge clk);
      check(sck_o == 0 && sck_oe == 0, "R9 no clock", {sck_o, sck_oe}, 0);
      rd(2'd1, v); check(v == 8'h00, "R9 no flag", v, 0);
      wr(2'd0, 8'h06);
      m_xfer(8'h24, 8'h99, cap);
      rd(2'd1, v);
      rd(2'd2, v); check(v == 8'h99, "R9 re-enabled", v, 8'h99);

      // R2/R6 follower exchange
      wr(2'd0, 8'h12);
      wr(2'd2, 8'h96);
      repeat (2) @(negedge clk);
      check(!miso_oe && !sck_oe && !mosi_oe, "R2 deselected", {miso_oe, sck_oe, mosi_oe}, 0);
      ssel_i = 1'b0;
      repeat (5) @(negedge clk);
      check(miso_oe && !sck_oe && !mosi_oe, "R2 selected", {miso_oe, sck_oe, mosi_oe}, 4);
      s_xfer(8'h5A, 8, got);
      check(got == 8'h96, "R6 miso", got, 8'h96);
      rd(2'd1, v); check(v[7], "R6 flag", v, 8'h80);
      rd(2'd2, v); check(v == 8'h5A, "R6 rx", v, 8'h5A);

      // R11 data read without status read keeps flag
      s_xfer(8'h81, 8, got);
      rd(2'd2, v);
      rd(2'd1, v); check(v[7], "R11 kept", v, 8'h80);
      rd(2'd2, v); check(v == 8'h81, "R6 second rx", v, 8'h81);
      rd(2'd1, v); check(v == 8'h00, "R11 clear", v, 0);

      // R4 partial byte dropped on select rise
      s_xfer(8'hFF, 3, got);
      ssel_i = 1'b1;
      repeat (6) @(negedge clk);
      check(miso_oe == 1'b0, "R2 released", miso_oe, 0);
      rd(2'd1, v); check(v == 8'h00, "R4 no flag", v, 0);
      ssel_i = 1'b0;
      repeat (5) @(negedge clk);
      s_xfer(8'h3C, 8, got);
      rd(2'd1, v); check(v[7], "R4 resync flag", v, 8'h80);
      rd(2'd2, v); check(v == 8'h3C, "R4 resync rx", v, 8'h3C);

      // R3 clocks ignored while deselected
      ssel_i = 1'b1;
      repeat (5) @(negedge clk);
      s_xfer(8'hE7, 8, got);
      rd(2'd1, v); check(v == 8'h00, "R3 no flag", v, 0);
      rd(2'd2, v); check(v == 8'h3C, "R3 rx kept", v, 8'h3C);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule